// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a down-counting watchdog whose counter can be started, refreshed or halted only through a two-word unlock pattern written to its control register. A first word arms a command and a second word carries it out. Any other control write drops the armed state. Once running, the counter falls by one on every cycle in which the `tick` input is high. If software fails to refresh it in time, the counter reaches zero. The block then raises `rst_req` for a fixed number of clock cycles and returns to the stopped state.

Each expiry sets a sticky cause flag. A warm reset does not clear it, so software can read it after the reset that the watchdog itself caused; only power-on reset clears it. A reset-select register chooses the internal-bus reset type. It is guarded by a write-enable bit inside the written word. A build parameter produces a variant that cannot be stopped. In that variant the disable words act exactly like the enable words.

The key tracker has three states: IDLE, EN_ARMED and DIS_ARMED. Writing the enable-arm word moves it to EN_ARMED from any state. Writing the disable-arm word moves it to DIS_ARMED from any state. Writing the matching second word from an armed state fires the command and returns the tracker to IDLE, and so does any other control write. The timer has three states: STOP, RUN and FIRE. STOP goes to RUN on start. RUN reloads on start, goes to STOP on stop, and goes to FIRE on the tick that takes the count from 1 to 0. FIRE goes to STOP after the pulse.

Top module: `keyed_wdt`

## Requirements
- R1: After power-on reset (`por_n` low), all of the following are zero: `rst_req`, `wdog_cause`, `rst_ib_sel`, the control status word (address 0), the reset-select word (address 1), the cause word (address 2) and the count (address 3).
- R2: Writing 0x1E1E1E1E and then 0xE1E1E1E1 to address 0 starts the timer. The count loads all ones (CNT_W bits) at the clock edge of the second write, then falls by one at each clock edge where `tick` is high.
- R3: Repeating the enable pair while the timer runs reloads the count to all ones (keep-alive).
- R4: Writing 0x1F1F1F1F and then 0xF1F1F1F1 stops a running timer. The count then holds its value whatever `tick` does.
- R5: A control write that is not the expected next word returns the tracker to IDLE. A second word written without its arm word directly before it has no effect on the timer.
- R6: With CAN_STOP = 0, 0x1F1F1F1F arms exactly as 0x1E1E1E1E does and 0xF1F1F1F1 acts as 0xE1E1E1E1, so the disable pair reloads the count and the timer keeps running.
- R7: The timer expires on the tick that takes the count from 1 to 0, which is 2^CNT_W − 1 ticks after a start. From the following cycle `rst_req` is high for exactly PULSE_CYC cycles.
- R8: Expiry sets `wdog_cause`, read as bit 5 of address 2. The flag stays set through `warm_rst_n`, and only `por_n` clears it.
- R9: A write to address 1 updates the reset-select bit (bit 0, driving `rst_ib_sel`) only when bit 31 of the written word is 1. The bit reads back at address 1 bit 0 and survives warm reset.
- R10: Reading address 0 returns status bits, not the written keys: bit 0 running, bit 1 enable armed, bit 2 disable armed, bit 3 firing.
- R11: After the pulse the timer stays stopped until a new enable pair is written. Commands written while firing are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears everything |
| warm_rst_n | input | 1 | Warm reset, active low, clears timer and key state only |
| tick | input | 1 | Count enable, one decrement per high cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 reset-select, 2 cause, 3 count |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| rst_req | output | 1 | Reset request pulse on expiry |
| rst_ib_sel | output | 1 | Selected reset type (internal-bus reset when 1) |
| wdog_cause | output | 1 | Sticky flag: last reset came from watchdog expiry |

## Verification
Register writes take effect at the clock edge that samples `reg_wr`, so state, count and status reads are due one cycle after the write. The bench drives inputs on the falling edge and samples there, half a cycle after the edge of interest. Expiry is counted exactly: after 2^CNT_W − 2 ticks from a start the count must read 1 with no request, and the next tick raises `rst_req` and the cause flag at the same edge. The pulse is checked as still high after PULSE_CYC − 1 further edges and low after PULSE_CYC. Reads are combinational and are sampled one time step after the address is set.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

    localparam logic [31:0] KEY_EN_ARM  = 32'h1E1E1E1E;
    localparam logic [31:0] KEY_EN_GO   = 32'hE1E1E1E1;
    localparam logic [31:0] KEY_DIS_ARM = 32'h1F1F1F1F;
    localparam logic [31:0] KEY_DIS_GO  = 32'hF1F1F1F1;

    localparam logic [1:0] ADDR_CTL   = 2'd0;
    localparam logic [1:0] ADDR_RSEL  = 2'd1;
    localparam logic [1:0] ADDR_CAUSE = 2'd2;
    localparam logic [1:0] ADDR_CNT   = 2'd3;

    localparam int CAUSE_BIT   = 5;
    localparam int RSEL_WE_BIT = 31;

    typedef enum logic [1:0] {
        ARM_IDLE = 2'd0,
        ARM_EN   = 2'd1,
        ARM_DIS  = 2'd2
    } arm_e;

    typedef enum logic [1:0] {
        TMR_STOP = 2'd0,
        TMR_RUN  = 2'd1,
        TMR_FIRE = 2'd2
    } tmr_e;

endpackage

// File: rtl/kwd_keyseq.sv
module kwd_keyseq
    import kwd_pkg::*;
#(
    parameter bit CAN_STOP = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_wr,
    input  logic [31:0] wdata,
    output logic        cmd_start,
    output logic        cmd_stop,
    output logic        arm_en,
    output logic        arm_dis
);

    arm_e state_q, state_d;
    logic is_en_arm, is_en_go, is_dis_arm, is_dis_go;

    generate
        if (CAN_STOP) begin : g_stoppable
            assign is_en_arm  = (wdata == KEY_EN_ARM);
            assign is_en_go   = (wdata == KEY_EN_GO);
            assign is_dis_arm = (wdata == KEY_DIS_ARM);
            assign is_dis_go  = (wdata == KEY_DIS_GO);
        end else begin : g_nostop
            assign is_en_arm  = (wdata == KEY_EN_ARM) || (wdata == KEY_DIS_ARM);
            assign is_en_go   = (wdata == KEY_EN_GO)  || (wdata == KEY_DIS_GO);
            assign is_dis_arm = 1'b0;
            assign is_dis_go  = 1'b0;
        end
    endgenerate

    always_comb begin
        state_d = state_q;
        if (ctl_wr) begin
            if (is_en_arm)       state_d = ARM_EN;
            else if (is_dis_arm) state_d = ARM_DIS;
            else                 state_d = ARM_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ARM_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        cmd_start = 1'b0;
        cmd_stop  = 1'b0;
        arm_en    = 1'b0;
        arm_dis   = 1'b0;
        unique case (state_q)
            ARM_IDLE: ;
            ARM_EN: begin
                arm_en    = 1'b1;
                cmd_start = ctl_wr && is_en_go;
            end
            ARM_DIS: begin
                arm_dis  = 1'b1;
                cmd_stop = ctl_wr && is_dis_go;
            end
            default: ;
        endcase
    end

    // R5
    stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wdata != KEY_EN_ARM && wdata != KEY_DIS_ARM) |=> (!arm_en && !arm_dis));

endmodule

// File: rtl/kwd_timer.sv
module kwd_timer
    import kwd_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int PULSE_CYC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cmd_start,
    input  logic             cmd_stop,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             firing,
    output logic             expire
);

    localparam int PW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [PW-1:0]    PULSE_LD = PW'(PULSE_CYC - 1);

    tmr_e             state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [PW-1:0]    pcnt_q, pcnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        pcnt_d  = pcnt_q;
        unique case (state_q)
            TMR_STOP: begin
                if (cmd_start) begin
                    state_d = TMR_RUN;
                    cnt_d   = '1;
                end
            end
            TMR_RUN: begin
                if (cmd_start) begin
                    cnt_d = '1;
                end else if (cmd_stop) begin
                    state_d = TMR_STOP;
                end else if (tick) begin
                    cnt_d = cnt_q - CNT_ONE;
                    if (cnt_q == CNT_ONE) begin
                        state_d = TMR_FIRE;
                        pcnt_d  = PULSE_LD;
                    end
                end
            end
            TMR_FIRE: begin
                if (pcnt_q == '0) state_d = TMR_STOP;
                else              pcnt_d  = pcnt_q - PW'(1);
            end
            default: state_d = TMR_STOP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TMR_STOP;
            cnt_q   <= '0;
            pcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            pcnt_q  <= pcnt_d;
        end
    end

    always_comb begin
        running = 1'b0;
        firing  = 1'b0;
        expire  = 1'b0;
        unique case (state_q)
            TMR_STOP: ;
            TMR_RUN: begin
                running = 1'b1;
                expire  = !cmd_start && !cmd_stop && tick && (cnt_q == CNT_ONE);
            end
            TMR_FIRE: firing = 1'b1;
            default: ;
        endcase
    end

    assign count = cnt_q;

    // R2
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && !firing) |=> (running && count == '1));

    // R2
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && !cmd_start && !cmd_stop && count > CNT_ONE) |=>
            (running && count == $past(count) - CNT_ONE));

    // R4
    stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cmd_stop && !cmd_start) |=> (!running && $stable(count)));

    // R7
    expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (firing && count == '0));

endmodule

// File: rtl/kwd_status.sv
module kwd_status
    import kwd_pkg::*;
(
    input  logic        clk,
    input  logic        por_n,
    input  logic        rsel_wr,
    input  logic [31:0] wdata,
    input  logic        expire,
    output logic        cause,
    output logic        rsel
);

    logic cause_q, rsel_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cause_q <= 1'b0;
            rsel_q  <= 1'b0;
        end else begin
            if (expire) cause_q <= 1'b1;
            if (rsel_wr && wdata[RSEL_WE_BIT]) rsel_q <= wdata[0];
        end
    end

    assign cause = cause_q;
    assign rsel  = rsel_q;

    // R8
    cause_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
        cause |=> cause);

    // R9
    rsel_guard_chk: assert property (@(posedge clk) disable iff (!por_n)
        (rsel_wr && !wdata[RSEL_WE_BIT]) |=> $stable(rsel));

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import kwd_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int PULSE_CYC = 16,
    parameter bit CAN_STOP  = 1'b1
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic        warm_rst_n,
    input  logic        tick,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        rst_req,
    output logic        rst_ib_sel,
    output logic        wdog_cause
);

    logic             core_rst_n;
    logic             ctl_wr, rsel_wr;
    logic             cmd_start, cmd_stop, arm_en, arm_dis;
    logic [CNT_W-1:0] count;
    logic             running, firing, expire;

    assign core_rst_n = por_n && warm_rst_n;
    assign ctl_wr     = reg_wr && (reg_addr == ADDR_CTL);
    assign rsel_wr    = reg_wr && (reg_addr == ADDR_RSEL);

    kwd_keyseq #(.CAN_STOP(CAN_STOP)) u_keys (
        .clk       (clk),
        .rst_n     (core_rst_n),
        .ctl_wr    (ctl_wr),
        .wdata     (reg_wdata),
        .cmd_start (cmd_start),
        .cmd_stop  (cmd_stop),
        .arm_en    (arm_en),
        .arm_dis   (arm_dis)
    );

    kwd_timer #(.CNT_W(CNT_W), .PULSE_CYC(PULSE_CYC)) u_timer (
        .clk       (clk),
        .rst_n     (core_rst_n),
        .tick      (tick),
        .cmd_start (cmd_start),
        .cmd_stop  (cmd_stop),
        .count     (count),
        .running   (running),
        .firing    (firing),
        .expire    (expire)
    );

    kwd_status u_status (
        .clk     (clk),
        .por_n   (por_n),
        .rsel_wr (rsel_wr),
        .wdata   (reg_wdata),
        .expire  (expire),
        .cause   (wdog_cause),
        .rsel    (rst_ib_sel)
    );

    assign rst_req = firing;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_CTL:   reg_rdata = {28'd0, firing, arm_dis, arm_en, running};
            ADDR_RSEL:  reg_rdata = {31'd0, rst_ib_sel};
            ADDR_CAUSE: reg_rdata[CAUSE_BIT] = wdog_cause;
            ADDR_CNT:   reg_rdata = 32'(count);
            default:    reg_rdata = '0;
        endcase
    end

    // R11
    fire_ignores_cmd_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
        (firing && cmd_start) |=> !running);

endmodule

// File: tb/keyed_wdt_tb.sv
module keyed_wdt_tb;

    localparam int W     = 12;
    localparam int PULSE = 16;
    localparam logic [31:0] ALL = (32'd1 << W) - 32'd1;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        warm_rst_n = 1'b1;
    logic        tick = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] rdata, rdata_ns;
    logic        rst_req, rst_ib_sel, wdog_cause;
    logic        rst_req_ns, rsel_ns, cause_ns;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    keyed_wdt #(.CNT_W(W), .PULSE_CYC(PULSE), .CAN_STOP(1'b1)) u_dut (
        .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n), .tick(tick),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(rdata), .rst_req(rst_req), .rst_ib_sel(rst_ib_sel),
        .wdog_cause(wdog_cause)
    );

    keyed_wdt #(.CNT_W(W), .PULSE_CYC(PULSE), .CAN_STOP(1'b0)) u_dut_nostop (
        .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n), .tick(tick),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(rdata_ns), .rst_req(rst_req_ns), .rst_ib_sel(rsel_ns),
        .wdog_cause(cause_ns)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d, output logic [31:0] dn);
        reg_addr = a;
        #1;
        d  = rdata;
        dn = rdata_ns;
    endtask

    task automatic run_ticks(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v, vn;
        chk("R1 rst_req", {31'd0, rst_req}, 32'd0);
        chk("R1 cause pin", {31'd0, wdog_cause}, 32'd0);
        chk("R1 rsel pin", {31'd0, rst_ib_sel}, 32'd0);
        rd(2'd0, v, vn); chk("R1 ctl", v, 32'd0);
        rd(2'd1, v, vn); chk("R1 rsel reg", v, 32'd0);
        rd(2'd2, v, vn); chk("R1 cause reg", v, 32'd0);
        rd(2'd3, v, vn); chk("R1 count", v, 32'd0);
    endtask

    task automatic t_start();
        logic [31:0] v, vn;
        wr(2'd0, 32'h1E1E1E1E);
        rd(2'd0, v, vn); chk("R10 enable armed", v, 32'h2);
        wr(2'd0, 32'hE1E1E1E1);
        rd(2'd0, v, vn); chk("R10 running", v, 32'h1);
        rd(2'd3, v, vn); chk("R2 load all ones", v, ALL);
        run_ticks(10);
        rd(2'd3, v, vn); chk("R2 ten ticks", v, ALL - 32'd10);
        for (int i = 0; i < 10; i++) begin
            tick = i[0];
            @(negedge clk);
        end
        tick = 1'b0;
        rd(2'd3, v, vn); chk("R2 sparse ticks", v, ALL - 32'd15);
    endtask

    task automatic t_keepalive();
        logic [31:0] v, vn;
        wr(2'd0, 32'h1E1E1E1E);
        wr(2'd0, 32'hE1E1E1E1);
        rd(2'd3, v, vn); chk("R3 reload", v, ALL);
    endtask

    task automatic t_badseq();
        logic [31:0] v, vn;
        run_ticks(5);
        wr(2'd0, 32'hE1E1E1E1);
        rd(2'd3, v, vn); chk("R5 lone go word", v, ALL - 32'd5);
        wr(2'd0, 32'h1E1E1E1E);
        wr(2'd0, 32'h12345678);
        rd(2'd0, v, vn); chk("R5 arm cleared", v, 32'h1);
        wr(2'd0, 32'hE1E1E1E1);
        rd(2'd3, v, vn); chk("R5 broken pair", v, ALL - 32'd5);
    endtask

    task automatic t_stop();
        logic [31:0] v, vn;
        run_ticks(3);
        wr(2'd0, 32'h1F1F1F1F);
        rd(2'd0, v, vn);
        chk("R10 disable armed", v, 32'h5);
        chk("R6 nostop arms enable", vn, 32'h3);
        wr(2'd0, 32'hF1F1F1F1);
        rd(2'd0, v, vn);
        chk("R4 stopped", v, 32'h0);
        chk("R6 nostop still running", vn, 32'h1);
        rd(2'd3, v, vn);
        chk("R4 count held", v, ALL - 32'd8);
        chk("R6 nostop reloaded", vn, ALL);
        run_ticks(5);
        rd(2'd3, v, vn);
        chk("R4 ticks ignored when stopped", v, ALL - 32'd8);
    endtask

    task automatic t_rsel();
        logic [31:0] v, vn;
        wr(2'd1, 32'h00000001);
        rd(2'd1, v, vn); chk("R9 no write enable", v, 32'd0);
        chk("R9 pin unchanged", {31'd0, rst_ib_sel}, 32'd0);
        wr(2'd1, 32'h80000001);
        rd(2'd1, v, vn); chk("R9 guarded write", v, 32'd1);
        wr(2'd1, 32'h00000000);
        rd(2'd1, v, vn); chk("R9 unguarded clear ignored", v, 32'd1);
    endtask

    task automatic t_expire();
        logic [31:0] v, vn;
        wr(2'd0, 32'h1E1E1E1E);
        wr(2'd0, 32'hE1E1E1E1);
        run_ticks(int'(ALL) - 1);
        rd(2'd3, v, vn); chk("R7 count one", v, 32'd1);
        chk("R7 no request yet", {31'd0, rst_req}, 32'd0);
        run_ticks(1);
        chk("R7 request raised", {31'd0, rst_req}, 32'd1);
        chk("R8 cause pin", {31'd0, wdog_cause}, 32'd1);
        rd(2'd0, v, vn); chk("R10 firing", v, 32'h8);
        wr(2'd0, 32'h1E1E1E1E);
        wr(2'd0, 32'hE1E1E1E1);
        repeat (PULSE - 3) @(negedge clk);
        chk("R7 request held", {31'd0, rst_req}, 32'd1);
        @(negedge clk);
        chk("R7 request dropped", {31'd0, rst_req}, 32'd0);
        rd(2'd0, v, vn); chk("R11 stopped after fire", v, 32'h0);
        run_ticks(5);
        rd(2'd3, v, vn); chk("R11 stays stopped", v, 32'd0);
    endtask

    task automatic t_resets();
        logic [31:0] v, vn;
        warm_rst_n = 1'b0;
        @(negedge clk);
        warm_rst_n = 1'b1;
        rd(2'd2, v, vn); chk("R8 cause survives warm reset", v, 32'h20);
        rd(2'd1, v, vn); chk("R9 rsel survives warm reset", v, 32'd1);
        wr(2'd0, 32'h1E1E1E1E);
        wr(2'd0, 32'hE1E1E1E1);
        rd(2'd0, v, vn); chk("R11 re-enable", v, 32'h1);
        por_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
        rd(2'd2, v, vn); chk("R8 cause cleared by por", v, 32'd0);
        rd(2'd1, v, vn); chk("R1 rsel cleared by por", v, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_start();
        t_keepalive();
        t_badseq();
        t_stop();
        t_rsel();
        t_expire();
        t_resets();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule